// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Generator

This block produces the five occupancy indications of a FIFO whose write and read sides run on unrelated clocks: an empty indication, almost-empty, half-full, almost-full and a full indication. It takes the binary write pointer from the write domain and the binary read pointer from the read domain. Each pointer is converted to Gray code, registered in its own domain and carried into the other domain through a two-stage synchronizer. Each domain then computes the word count from its local pointer and the synchronized remote pointer. The memory array and the offset register access sit outside this block.

Two configuration pins are captured on every clock edge while reset is held. After reset they are frozen. The first pin selects the partial-flag timing. In split timing, almost-empty is set by a read-clock edge and cleared by a write-clock edge, and almost-full is set by a write-clock edge and cleared by a read-clock edge. In single-clock timing, almost-empty updates only on read-clock edges and almost-full only on write-clock edges. The second pin selects the output-stage mode. In the registered-output mode the empty and full indications are active low. In the look-ahead mode the output stage holds one extra word, so every threshold moves up by one word, and both indications become active-high "no data" and "at capacity" signals.

The partial flags are built from a small cell. For single-clock timing it uses a two-state machine with states `FLG_OFF` and `FLG_ON`. The transition `FLG_OFF -> FLG_ON` is taken on a set-clock edge when the threshold condition holds. The transition `FLG_ON -> FLG_OFF` is taken on a set-clock edge when the condition does not hold. For split timing the cell uses a pair of toggle bits, one in each clock domain. The set domain flips its bit to assert the flag and the clear domain flips its bit to release it.

Top module: `fflag_status`

## Requirements
- R1: While reset is low, after at least one edge of each clock, the outputs show the zero-word state. In registered-output mode: empty_flag=0, ae_n=0, hf_n=1, af_n=1, full_flag=1. In look-ahead mode: empty_flag=1, full_flag=0.
- R2: In registered-output mode, once the pointers are stable, empty_flag is 0 exactly when the word count (wr_ptr minus rd_ptr, modulo 2^(AW+2)) is zero. This holds across pointer wrap.
- R3: In registered-output mode, ae_n is 0 when the word count is at most ae_offset, and 1 above it.
- R4: In registered-output mode, hf_n is 0 when the word count is at least DEPTH/2+1.
- R5: In registered-output mode, af_n is 0 when the word count is at least DEPTH-af_offset.
- R6: In registered-output mode, full_flag is 0 only at DEPTH words.
- R7: In look-ahead mode, every threshold of R3 to R6 is one word higher. empty_flag is 1 at zero words and full_flag is 1 only at DEPTH+1 words, which is the largest legal word count.
- R8: With split timing (cfg_sync_timing=0 at reset), writes release ae_n using write-clock edges alone while the read clock is stopped. Reads release af_n using read-clock edges alone while the write clock is stopped.
- R9: With single-clock timing (cfg_sync_timing=1 at reset), ae_n does not change while the read clock is stopped and af_n does not change while the write clock is stopped. Each flag settles once its own clock runs again.
- R10: Changing cfg_sync_timing or cfg_fwft after reset has no effect until the next reset.
- R11: Flags stay mutually consistent. Full implies half-full. With single-clock timing, empty implies almost-empty and full implies almost-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; configuration is captured while it is low |
| cfg_fwft | input | 1 | 1 selects look-ahead output mode, 0 selects registered-output mode |
| cfg_sync_timing | input | 1 | 1 selects single-clock partial-flag timing, 0 selects split timing |
| ae_offset | input | OW | Almost-empty threshold in words |
| af_offset | input | OW | Almost-full distance below capacity in words |
| wr_ptr | input | AW+2 | Binary write pointer, write domain |
| rd_ptr | input | AW+2 | Binary read pointer, read domain |
| empty_flag | output | 1 | Empty indication; polarity set by mode |
| ae_n | output | 1 | Almost-empty, active low |
| hf_n | output | 1 | Half-full, active low, write domain |
| af_n | output | 1 | Almost-full, active low |
| full_flag | output | 1 | Full indication; polarity set by mode |

## Verification
In split timing a partial flag can be asserted by an edge of one clock and released by an edge of the other. The two clocks can have edges in the same instant, and either clock can be stopped. The bench runs the clocks at 5 ns and 7 ns, so their rising edges meet every 35 ns. It also gates one clock off while the other moves the pointers, so that the release must come from the surviving domain alone. Each scenario is judged against a word-count model after both domains have settled. With the same scenario under single-clock timing, the flag must hold its value until its own clock runs again.

// File: rtl/fflag_pkg.sv
`timescale 1ns/1ps
package fflag_pkg;
    typedef enum logic {
        FLG_OFF = 1'b0,
        FLG_ON  = 1'b1
    } flag_state_e;
endpackage

// File: rtl/fflag_sync.sv
`timescale 1ns/1ps
module fflag_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/fflag_partial.sv
`timescale 1ns/1ps
module fflag_partial
    import fflag_pkg::*;
#(
    parameter bit RESET_ON = 1'b0
) (
    input  logic set_clk,
    input  logic clr_clk,
    input  logic rst_n,
    input  logic sync_s,
    input  logic sync_c,
    input  logic hit_set,
    input  logic miss_clr,
    output logic flag_on
);
    localparam flag_state_e RST_ST = RESET_ON ? FLG_ON : FLG_OFF;

    flag_state_e state_q, state_d;
    logic        tog_s, tog_c, split_on;

    // split timing: flag is the difference of two toggles, one per domain
    assign split_on = tog_s ^ tog_c;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_OFF: if (hit_set)  state_d = FLG_ON;
            FLG_ON:  if (!hit_set) state_d = FLG_OFF;
        endcase
    end

    always_ff @(posedge set_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_ST;
            tog_s   <= RESET_ON;
        end else if (sync_s) begin
            state_q <= state_d;
        end else if (hit_set && !split_on) begin
            tog_s <= ~tog_s;
        end
    end

    always_ff @(posedge clr_clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_c <= 1'b0;
        end else if (!sync_c && miss_clr && split_on) begin
            tog_c <= ~tog_c;
        end
    end

    always_comb begin
        flag_on = sync_s ? (state_q == FLG_ON) : split_on;
    end
endmodule

// File: rtl/fflag_status.sv
`timescale 1ns/1ps
module fflag_status #(
    parameter int AW = 8,
    parameter int OW = AW
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_sync_timing,
    input  logic [OW-1:0] ae_offset,
    input  logic [OW-1:0] af_offset,
    input  logic [AW+1:0] wr_ptr,
    input  logic [AW+1:0] rd_ptr,
    output logic          empty_flag,
    output logic          ae_n,
    output logic          hf_n,
    output logic          af_n,
    output logic          full_flag
);
    localparam int PW    = AW + 2;
    localparam int TW    = PW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [TW-1:0] DEPTH_T = TW'(DEPTH);
    localparam logic [TW-1:0] HALF_T  = TW'(DEPTH / 2 + 1);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // configuration captured on each clock while reset is held
    logic fwft_w, sync_w, fwft_r, sync_r;

    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            fwft_w <= cfg_fwft;
            sync_w <= cfg_sync_timing;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            fwft_r <= cfg_fwft;
            sync_r <= cfg_sync_timing;
        end
    end

    // pointer crossing
    logic [PW-1:0] wgray_q, rgray_q, wgray_s, rgray_s;
    logic [PW-1:0] wsync_bin, rsync_bin, occ_w, occ_r;

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wgray_q <= '0;
        else        wgray_q <= to_gray(wr_ptr);
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rgray_q <= '0;
        else        rgray_q <= to_gray(rd_ptr);
    end

    fflag_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray_q), .q(wgray_s));
    fflag_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray_q), .q(rgray_s));

    assign wsync_bin = from_gray(wgray_s);
    assign rsync_bin = from_gray(rgray_s);
    assign occ_r     = wsync_bin - rd_ptr;
    assign occ_w     = wr_ptr - rsync_bin;

    // thresholds, shifted one word up in look-ahead mode
    logic [TW-1:0] occ_w_t, occ_r_t;
    logic [TW-1:0] ae_thr_w, ae_thr_r, af_thr_w, af_thr_r, hf_thr_w, full_thr_w;
    logic          ae_hit_r, ae_miss_w, af_hit_w, af_miss_r;

    always_comb begin
        occ_w_t    = TW'(occ_w);
        occ_r_t    = TW'(occ_r);
        ae_thr_w   = TW'(ae_offset) + TW'(fwft_w);
        ae_thr_r   = TW'(ae_offset) + TW'(fwft_r);
        af_thr_w   = DEPTH_T - TW'(af_offset) + TW'(fwft_w);
        af_thr_r   = DEPTH_T - TW'(af_offset) + TW'(fwft_r);
        hf_thr_w   = HALF_T + TW'(fwft_w);
        full_thr_w = DEPTH_T + TW'(fwft_w);
        ae_hit_r   = occ_r_t <= ae_thr_r;
        ae_miss_w  = occ_w_t >  ae_thr_w;
        af_hit_w   = occ_w_t >= af_thr_w;
        af_miss_r  = occ_r_t <  af_thr_r;
    end

    // boundary flags
    logic empty_on, full_on, hf_on, ae_on, af_on;

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) empty_on <= 1'b1;
        else        empty_on <= (occ_r == '0);
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            full_on <= 1'b0;
            hf_on   <= 1'b0;
        end else begin
            full_on <= occ_w_t >= full_thr_w;
            hf_on   <= occ_w_t >= hf_thr_w;
        end
    end

    fflag_partial #(.RESET_ON(1'b1)) u_ae (
        .set_clk (rd_clk),
        .clr_clk (wr_clk),
        .rst_n   (rst_n),
        .sync_s  (sync_r),
        .sync_c  (sync_w),
        .hit_set (ae_hit_r),
        .miss_clr(ae_miss_w),
        .flag_on (ae_on)
    );

    fflag_partial #(.RESET_ON(1'b0)) u_af (
        .set_clk (wr_clk),
        .clr_clk (rd_clk),
        .rst_n   (rst_n),
        .sync_s  (sync_w),
        .sync_c  (sync_r),
        .hit_set (af_hit_w),
        .miss_clr(af_miss_r),
        .flag_on (af_on)
    );

    always_comb begin
        empty_flag = fwft_r ? empty_on : ~empty_on;
        full_flag  = fwft_w ? full_on  : ~full_on;
        ae_n       = ~ae_on;
        hf_n       = ~hf_on;
        af_n       = ~af_on;
    end
endmodule

// File: rtl/fflag_status_chk.sv
`timescale 1ns/1ps
module fflag_status_chk #(
    parameter int AW = 8
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          sync_w,
    input logic          sync_r,
    input logic          empty_on,
    input logic          full_on,
    input logic          hf_on,
    input logic          ae_on,
    input logic          af_on,
    input logic [AW+1:0] occ_w
);
    localparam int CAP = (1 << AW) + 1;

    // R1
    wr_reset_state_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!full_on && !hf_on && !af_on));

    // R1
    rd_reset_state_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty_on && ae_on));

    // R11
    full_implies_half_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full_on |-> hf_on);

    // R11
    empty_implies_ae_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (sync_r && empty_on) |-> ae_on);

    // R11
    full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (sync_w && full_on) |-> af_on);

    // R7
    occ_bound_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        int'(occ_w) <= CAP);
endmodule

bind fflag_status fflag_status_chk #(.AW(AW)) u_chk (
    .wr_clk  (wr_clk),
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .sync_w  (sync_w),
    .sync_r  (sync_r),
    .empty_on(empty_on),
    .full_on (full_on),
    .hf_on   (hf_on),
    .ae_on   (ae_on),
    .af_on   (af_on),
    .occ_w   (occ_w)
);

// File: tb/fflag_status_bench.sv
`timescale 1ns/1ps
module fflag_status_bench;
    localparam int AW    = 8;
    localparam int PW    = AW + 2;
    localparam int DEPTH = 1 << AW;
    localparam int AEO   = 31;
    localparam int AFO   = 31;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_run = 1'b1, rd_run = 1'b1;
    logic rst_n = 1'b0, cfg_fwft = 1'b0, cfg_sync = 1'b0;
    logic [PW-1:0] wr_ptr = '0, rd_ptr = '0;
    logic empty_flag, ae_n, hf_n, af_n, full_flag;

    int  wcnt = 0, rcnt = 0;
    int  n_run = 0, n_fail = 0;
    bit  fwft_m = 1'b0;
    bit  done = 1'b0;

    always #2.5 if (wr_run) wr_clk = ~wr_clk;
    always #3.5 if (rd_run) rd_clk = ~rd_clk;

    fflag_status #(.AW(AW), .OW(AW)) u_fflag_status (
        .wr_clk         (wr_clk),
        .rd_clk         (rd_clk),
        .rst_n          (rst_n),
        .cfg_fwft       (cfg_fwft),
        .cfg_sync_timing(cfg_sync),
        .ae_offset      (AW'(AEO)),
        .af_offset      (AW'(AFO)),
        .wr_ptr         (wr_ptr),
        .rd_ptr         (rd_ptr),
        .empty_flag     (empty_flag),
        .ae_n           (ae_n),
        .hf_n           (hf_n),
        .af_n           (af_n),
        .full_flag      (full_flag)
    );

    task automatic check_bit(string req, string nm, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s words=%0d actual=%b expected=%b", req, nm, wcnt - rcnt, act, exp);
        end
    endtask

    // word-count reference model
    task automatic check_all(string req);
        int  w  = wcnt - rcnt;
        int  sh = fwft_m ? 1 : 0;
        bit  emp  = (w == 0);
        bit  ae   = (w <= AEO + sh);
        bit  hf   = (w >= DEPTH / 2 + 1 + sh);
        bit  af   = (w >= DEPTH - AFO + sh);
        bit  full = (w >= DEPTH + sh);
        check_bit(req, "empty_flag", empty_flag, fwft_m ? emp : !emp);
        check_bit(req, "ae_n", ae_n, !ae);
        check_bit(req, "hf_n", hf_n, !hf);
        check_bit(req, "af_n", af_n, !af);
        check_bit(req, "full_flag", full_flag, fwft_m ? full : !full);
    endtask

    task automatic settle();
        repeat (8) @(posedge wr_clk);
        repeat (8) @(posedge rd_clk);
        #0.2;
    endtask

    task automatic do_write(int n);
        @(negedge wr_clk);
        wcnt += n;
        wr_ptr = PW'(wcnt);
    endtask

    task automatic do_read(int n);
        @(negedge rd_clk);
        rcnt += n;
        rd_ptr = PW'(rcnt);
    endtask

    task automatic move_to(int target);
        int w = wcnt - rcnt;
        if (target > w) do_write(target - w);
        else if (target < w) do_read(w - target);
        settle();
    endtask

    task automatic do_reset(bit fw, bit sy);
        rst_n    = 1'b0;
        cfg_fwft = fw;
        cfg_sync = sy;
        fwft_m   = fw;
        wr_run   = 1'b1;
        rd_run   = 1'b1;
        wcnt = 0; rcnt = 0;
        wr_ptr = '0; rd_ptr = '0;
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        #0.2;
        check_all("R1");
        @(negedge wr_clk);
        rst_n = 1'b1;
        settle();
    endtask

    // R8 / R10: almost-empty released by write clock alone
    task automatic ae_release_wr_only(string req, logic exp_ae);
        move_to(0);
        rd_run = 1'b0;
        do_write(40);
        repeat (10) @(posedge wr_clk);
        #0.2;
        check_bit(req, "ae_n (read clock stopped)", ae_n, exp_ae);
        rd_run = 1'b1;
        settle();
        check_all(req);
    endtask

    task automatic af_release_rd_only(string req, logic exp_af);
        move_to(250);
        check_all(req);
        wr_run = 1'b0;
        do_read(30);
        repeat (10) @(posedge rd_clk);
        #0.2;
        check_bit(req, "af_n (write clock stopped)", af_n, exp_af);
        wr_run = 1'b1;
        settle();
        check_all(req);
    endtask

    initial begin
        // registered-output mode, split timing
        do_reset(1'b0, 1'b0);
        move_to(1);   check_all("R2");
        move_to(31);  check_all("R3");
        move_to(32);  check_all("R3");
        move_to(128); check_all("R4");
        move_to(129); check_all("R4");
        move_to(224); check_all("R5");
        move_to(225); check_all("R5");
        move_to(255); check_all("R6");
        move_to(256); check_all("R6");
        move_to(100); check_all("R5");
        move_to(0);   check_all("R2");
        for (int i = 0; i < 6; i++) begin
            move_to(200); check_all("R2");
            move_to(5);   check_all("R2");
        end
        ae_release_wr_only("R8", 1'b1);
        af_release_rd_only("R8", 1'b1);

        // pins changed after reset must not matter
        cfg_sync = 1'b1;
        cfg_fwft = 1'b1;
        ae_release_wr_only("R10", 1'b1);
        move_to(256); check_all("R10");
        cfg_sync = 1'b0;
        cfg_fwft = 1'b0;

        // single-clock timing
        do_reset(1'b0, 1'b1);
        ae_release_wr_only("R9", 1'b0);
        af_release_rd_only("R9", 1'b0);
        move_to(256); check_all("R9");
        move_to(0);   check_all("R9");

        // look-ahead mode
        do_reset(1'b1, 1'b0);
        move_to(1);   check_all("R7");
        move_to(32);  check_all("R7");
        move_to(33);  check_all("R7");
        move_to(129); check_all("R7");
        move_to(130); check_all("R7");
        move_to(225); check_all("R7");
        move_to(226); check_all("R7");
        move_to(256); check_all("R7");
        move_to(257); check_all("R7");
        move_to(0);   check_all("R7");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule